// File: doc/BRIEF.md
# CAN Receive Acceptance Filter

This block decides, for each received CAN identifier, whether the frame is accepted and into which message object it goes. It holds a bank of fifteen message objects, each carrying an identifier, a valid flag, a direction flag (receive or transmit) and a frame-format flag (standard 11-bit or extended 29-bit). A receive strobe presents an identifier and its format flag. The block compares that identifier with every valid receive object of the same format. Bits are excluded from the comparison by a global mask. There is one global mask for standard frames and one for extended frames.

The last object is receive-only and applies a second, object-local mask on top of the global one. This lets a whole group of identifiers land in that object. When several objects match, the lowest-numbered one wins. The last object therefore acts as a catch-all behind the fourteen general objects. Objects and masks are loaded through a single-cycle write port. The decision is registered and appears one clock after the strobe.

Top module: `can_accept_filter`

## Requirements
- R1: While `rst_ni` is low and after its release, `hit_o` is 0 and `hit_idx_o` is 0. All objects start invalid and all three masks start all-ones, where a mask bit of 1 means "must match".
- R2: `hit_o` is high only in the cycle after a cycle with `rx_stb_i` high. Without a strobe, no hit is reported even if the identifier matches. `hit_idx_o` is 0 whenever `hit_o` is 0.
- R3: An object matches when it is valid and set to receive. Its format flag must equal `rx_ext_i`, and every masked-in identifier bit must equal the received identifier. A strobe uses the configuration held before any write in the same cycle.
- R4: A global mask bit of 0 excludes that identifier bit. Standard frames compare only `rx_id_i[10:0]` under the standard mask (`cfg_sel_i`=1, `cfg_id_i[10:0]`). Extended frames compare all 29 bits under the extended mask (`cfg_sel_i`=2).
- R5: Object 15 compares under the active global mask ANDed with its local mask (`cfg_sel_i`=3). It is always a receive object, whatever `cfg_rx_i` was at its write.
- R6: On several matches, `hit_idx_o` reports the lowest object number (1..15). Object 15 is reported only when none of objects 1..14 matches.
- R7: Invalid objects and transmit objects (`cfg_rx_i`=0 at write) never match.
- R8: An object write (`cfg_sel_i`=0) with `cfg_idx_i` of 0 changes no object.
- R9: A standard frame never matches an extended object, and an extended frame never matches a standard object, even when their identifier bits agree.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_sel_i | input | 2 | Write target: 0 object, 1 standard mask, 2 extended mask, 3 last-object mask |
| cfg_idx_i | input | 4 | Object number 1..15 for object writes |
| cfg_id_i | input | 29 | Identifier or mask value |
| cfg_valid_i | input | 1 | Object valid flag |
| cfg_rx_i | input | 1 | Object direction, 1 = receive |
| cfg_ext_i | input | 1 | Object format, 1 = extended |
| rx_stb_i | input | 1 | Received identifier strobe |
| rx_id_i | input | 29 | Received identifier, standard in bits 10:0 |
| rx_ext_i | input | 1 | Received frame is extended |
| hit_o | output | 1 | Frame accepted (registered) |
| hit_idx_o | output | 4 | Accepting object number, 0 on no hit |

## Verification
The assertions assume that `rst_ni` is released away from a clock edge and that all inputs are known after reset. They also assume that object writes address 0..15, so no out-of-range index reaches the bank. The bench keeps within this. It drives every input on the falling edge from one task. It holds strobe and write low during reset. It draws object numbers only from 0..15 and identifiers from a small pool, so that overlapping matches and the priority rule are actually hit.

// File: rtl/can_filt_pkg.sv
package can_filt_pkg;
  localparam int STD_ID_W = 11;
  localparam int EXT_ID_W = 29;

  typedef enum logic [1:0] {
    SEL_OBJ  = 2'd0,
    SEL_GSTD = 2'd1,
    SEL_GEXT = 2'd2,
    SEL_LAST = 2'd3
  } cfg_sel_e;

  typedef struct packed {
    logic                valid;
    logic                rx;
    logic                ext;
    logic [EXT_ID_W-1:0] id;
  } obj_t;
endpackage

// File: rtl/can_filt_regs.sv
module can_filt_regs
  import can_filt_pkg::*;
#(
  parameter int N_OBJ = 15,
  parameter int IDX_W = 4
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                cfg_we_i,
  input  cfg_sel_e            cfg_sel_i,
  input  logic [IDX_W-1:0]    cfg_idx_i,
  input  logic [EXT_ID_W-1:0] cfg_id_i,
  input  logic                cfg_valid_i,
  input  logic                cfg_rx_i,
  input  logic                cfg_ext_i,
  output obj_t [N_OBJ-1:0]    obj_o,
  output logic [STD_ID_W-1:0] gmask_std_o,
  output logic [EXT_ID_W-1:0] gmask_ext_o,
  output logic [EXT_ID_W-1:0] lmask_o
);
  obj_t [N_OBJ-1:0] obj_q;

  for (genvar i = 0; i < N_OBJ; i++) begin : g_obj
    localparam logic IS_LAST = (i == N_OBJ - 1);
    logic wr_hit;
    assign wr_hit = cfg_we_i && (cfg_sel_i == SEL_OBJ) && (cfg_idx_i == IDX_W'(i + 1));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        obj_q[i] <= '0;
      end else if (wr_hit) begin
        obj_q[i].valid <= cfg_valid_i;
        obj_q[i].rx    <= IS_LAST ? 1'b1 : cfg_rx_i;  // last object receive-only
        obj_q[i].ext   <= cfg_ext_i;
        obj_q[i].id    <= cfg_id_i;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gmask_std_o <= '1;
      gmask_ext_o <= '1;
      lmask_o     <= '1;
    end else if (cfg_we_i) begin
      case (cfg_sel_i)
        SEL_GSTD: gmask_std_o <= cfg_id_i[STD_ID_W-1:0];
        SEL_GEXT: gmask_ext_o <= cfg_id_i;
        SEL_LAST: lmask_o     <= cfg_id_i;
        default:  ;
      endcase
    end
  end

  assign obj_o = obj_q;

  assert_bad_idx_ignored_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_we_i && cfg_sel_i == SEL_OBJ && (cfg_idx_i == '0 || cfg_idx_i > IDX_W'(N_OBJ)))
      |=> $stable(obj_q));
endmodule

// File: rtl/can_filt_cmp.sv
module can_filt_cmp
  import can_filt_pkg::*;
#(
  parameter bit LAST = 1'b0
) (
  input  obj_t                obj_i,
  input  logic [STD_ID_W-1:0] gmask_std_i,
  input  logic [EXT_ID_W-1:0] gmask_ext_i,
  input  logic [EXT_ID_W-1:0] lmask_i,
  input  logic [EXT_ID_W-1:0] rx_id_i,
  input  logic                rx_ext_i,
  output logic                match_o
);
  logic [EXT_ID_W-1:0] gmask;
  logic [EXT_ID_W-1:0] mask_eff;
  logic [EXT_ID_W-1:0] diff;

  assign gmask = rx_ext_i ? gmask_ext_i : {{(EXT_ID_W - STD_ID_W){1'b0}}, gmask_std_i};

  if (LAST) begin : g_group
    assign mask_eff = gmask & lmask_i;
  end else begin : g_plain
    assign mask_eff = gmask;
  end

  assign diff    = (rx_id_i ^ obj_i.id) & mask_eff;
  assign match_o = obj_i.valid && obj_i.rx && (obj_i.ext == rx_ext_i) && (diff == '0);
endmodule

// File: rtl/can_filt_prio.sv
module can_filt_prio #(
  parameter int N_OBJ = 15,
  parameter int IDX_W = 4
) (
  input  logic [N_OBJ-1:0] match_i,
  output logic             any_o,
  output logic [IDX_W-1:0] idx_o
);
  always_comb begin
    any_o = |match_i;
    idx_o = '0;
    for (int k = N_OBJ - 1; k >= 0; k--) begin
      if (match_i[k]) idx_o = IDX_W'(k + 1);
    end
  end
endmodule

// File: rtl/can_accept_filter.sv
module can_accept_filter
  import can_filt_pkg::*;
#(
  parameter  int N_OBJ = 15,
  localparam int IDX_W = $clog2(N_OBJ + 1)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                cfg_we_i,
  input  logic [1:0]          cfg_sel_i,
  input  logic [IDX_W-1:0]    cfg_idx_i,
  input  logic [28:0]         cfg_id_i,
  input  logic                cfg_valid_i,
  input  logic                cfg_rx_i,
  input  logic                cfg_ext_i,
  input  logic                rx_stb_i,
  input  logic [28:0]         rx_id_i,
  input  logic                rx_ext_i,
  output logic                hit_o,
  output logic [IDX_W-1:0]    hit_idx_o
);
  obj_t [N_OBJ-1:0]    obj;
  logic [STD_ID_W-1:0] gmask_std;
  logic [EXT_ID_W-1:0] gmask_ext;
  logic [EXT_ID_W-1:0] lmask;
  logic [N_OBJ-1:0]    match_vec;
  logic                any_match;
  logic [IDX_W-1:0]    win_idx;

  can_filt_regs #(.N_OBJ(N_OBJ), .IDX_W(IDX_W)) u_regs (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .cfg_we_i    (cfg_we_i),
    .cfg_sel_i   (cfg_sel_e'(cfg_sel_i)),
    .cfg_idx_i   (cfg_idx_i),
    .cfg_id_i    (cfg_id_i),
    .cfg_valid_i (cfg_valid_i),
    .cfg_rx_i    (cfg_rx_i),
    .cfg_ext_i   (cfg_ext_i),
    .obj_o       (obj),
    .gmask_std_o (gmask_std),
    .gmask_ext_o (gmask_ext),
    .lmask_o     (lmask)
  );

  for (genvar i = 0; i < N_OBJ; i++) begin : g_cmp
    can_filt_cmp #(.LAST(i == N_OBJ - 1)) u_cmp (
      .obj_i       (obj[i]),
      .gmask_std_i (gmask_std),
      .gmask_ext_i (gmask_ext),
      .lmask_i     (lmask),
      .rx_id_i     (rx_id_i),
      .rx_ext_i    (rx_ext_i),
      .match_o     (match_vec[i])
    );
  end

  can_filt_prio #(.N_OBJ(N_OBJ), .IDX_W(IDX_W)) u_prio (
    .match_i (match_vec),
    .any_o   (any_match),
    .idx_o   (win_idx)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hit_o     <= 1'b0;
      hit_idx_o <= '0;
    end else begin
      hit_o     <= rx_stb_i && any_match;
      hit_idx_o <= (rx_stb_i && any_match) ? win_idx : '0;
    end
  end

  // one-hot of the reported object, used by the priority checks
  logic [N_OBJ-1:0] hit_onehot;
  assign hit_onehot = N_OBJ'(1) << (hit_idx_o - IDX_W'(1));

  assert_no_strobe_no_hit_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rx_stb_i |=> !hit_o);

  assert_idle_idx_zero_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hit_o |-> hit_idx_o == '0);

  assert_idx_range_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_o |-> (hit_idx_o != '0) && (hit_idx_o <= IDX_W'(N_OBJ)));

  assert_winner_matched_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_o |-> ($past(match_vec) & hit_onehot) != '0);

  assert_lowest_wins_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_o |-> ($past(match_vec) & (hit_onehot - N_OBJ'(1))) == '0);

  assert_last_is_fallback_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit_o && hit_idx_o == IDX_W'(N_OBJ)) |-> $past(match_vec[N_OBJ-2:0]) == '0);
endmodule

// File: tb/can_accept_filter_bench.sv
module can_accept_filter_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_sel = '0;
  logic [3:0]  cfg_idx = '0;
  logic [28:0] cfg_id = '0;
  logic        cfg_valid = 1'b0, cfg_rx = 1'b0, cfg_ext = 1'b0;
  logic        rx_stb = 1'b0;
  logic [28:0] rx_id = '0;
  logic        rx_ext = 1'b0;
  logic        hit;
  logic [3:0]  hit_idx;

  int n_checks = 0;
  int n_fail = 0;

  // reference state
  logic        mv [1:15];
  logic        mr [1:15];
  logic        me [1:15];
  logic [28:0] mid[1:15];
  logic [10:0] gstd;
  logic [28:0] gext, lm;
  logic        exp_hit;
  int          exp_idx;

  always #(CLK_PERIOD/2) clk = ~clk;

  can_accept_filter u_can_accept_filter (
    .clk_i(clk), .rst_ni(rst_ni),
    .cfg_we_i(cfg_we), .cfg_sel_i(cfg_sel), .cfg_idx_i(cfg_idx), .cfg_id_i(cfg_id),
    .cfg_valid_i(cfg_valid), .cfg_rx_i(cfg_rx), .cfg_ext_i(cfg_ext),
    .rx_stb_i(rx_stb), .rx_id_i(rx_id), .rx_ext_i(rx_ext),
    .hit_o(hit), .hit_idx_o(hit_idx)
  );

  task automatic model_reset();
    for (int o = 1; o <= 15; o++) begin
      mv[o] = 0; mr[o] = 0; me[o] = 0; mid[o] = '0;
    end
    gstd = '1; gext = '1; lm = '1;
    exp_hit = 0; exp_idx = 0;
  endtask

  task automatic model_eval();
    exp_hit = 0; exp_idx = 0;
    if (rx_stb) begin
      for (int o = 1; o <= 15; o++) begin
        logic [28:0] m;
        m = rx_ext ? gext : {18'b0, gstd};
        if (o == 15) m = m & lm;
        if (!exp_hit && mv[o] && mr[o] && me[o] == rx_ext && ((rx_id ^ mid[o]) & m) == '0) begin
          exp_hit = 1; exp_idx = o;
        end
      end
    end
  endtask

  task automatic model_write();
    if (cfg_we) begin
      case (cfg_sel)
        2'd0: if (cfg_idx >= 1) begin
          mv[cfg_idx] = cfg_valid; mr[cfg_idx] = (cfg_idx == 15) ? 1'b1 : cfg_rx;
          me[cfg_idx] = cfg_ext;   mid[cfg_idx] = cfg_id;
        end
        2'd1: gstd = cfg_id[10:0];
        2'd2: gext = cfg_id;
        default: lm = cfg_id;
      endcase
    end
  endtask

  task automatic check(input string tag);
    n_checks++;
    if (hit !== exp_hit || hit_idx !== 4'(exp_idx)) begin
      n_fail++;
      $display("FAIL %s: hit=%0b idx=%0d expected hit=%0b idx=%0d", tag, hit, hit_idx, exp_hit, exp_idx);
    end
  endtask

  // one clock: drive on falling edge, model, compare at next falling edge
  task automatic step(input logic we, input logic [1:0] sel, input logic [3:0] idx,
                      input logic [28:0] id, input logic v, input logic r, input logic e,
                      input logic stb, input logic [28:0] rid, input logic rext, input string tag);
    cfg_we = we; cfg_sel = sel; cfg_idx = idx; cfg_id = id;
    cfg_valid = v; cfg_rx = r; cfg_ext = e;
    rx_stb = stb; rx_id = rid; rx_ext = rext;
    model_eval();
    model_write();
    @(posedge clk);
    @(negedge clk);
    check(tag);
  endtask

  task automatic wr_obj(input int o, input logic [28:0] id, input logic v, input logic r, input logic e);
    step(1, 2'd0, 4'(o), id, v, r, e, 0, '0, 0, "cfg");
  endtask

  task automatic wr_mask(input logic [1:0] sel, input logic [28:0] m);
    step(1, sel, 4'd0, m, 0, 0, 0, 0, '0, 0, "cfg");
  endtask

  task automatic probe(input logic [28:0] rid, input logic rext, input string tag);
    step(0, 2'd0, 4'd0, '0, 0, 0, 0, 1, rid, rext, tag);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_fail++;
    $display("FAIL watchdog: run did not complete, actual=hung expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    model_reset();
    repeat (3) @(negedge clk);
    check("R1 in reset");
    rst_ni = 1'b1;
    @(negedge clk);
    check("R1 after release");
    probe(29'h000, 0, "R1 objects start invalid");
    probe(29'h000, 1, "R1 objects start invalid ext");

    wr_obj(3, 29'h123, 1, 1, 0);
    wr_obj(5, 29'h123, 1, 1, 0);
    probe(29'h123, 0, "R6 lowest of 3 and 5");
    probe(29'h124, 0, "R3 id mismatch");
    probe(29'h1000_0123, 0, "R4 std ignores upper bits");
    probe(29'h123, 1, "R9 ext frame vs std objects");
    step(0, 2'd0, 4'd0, '0, 0, 0, 0, 0, 29'h123, 0, "R2 no strobe no hit");

    wr_mask(2'd1, 29'h7F0);
    probe(29'h12A, 0, "R4 std mask dont care");
    wr_obj(7, 29'h1ABC_DE12, 1, 1, 1);
    probe(29'h1ABC_DE12, 1, "R3 ext exact");
    probe(29'h1ABC_DE13, 1, "R4 ext mask still full");
    probe(29'h0000_0012, 0, "R9 std frame vs ext object");
    wr_mask(2'd2, 29'h1FFF_FF00);
    probe(29'h1ABC_DE55, 1, "R4 ext mask dont care");

    wr_obj(3, 29'h123, 1, 0, 0);
    probe(29'h123, 0, "R7 transmit object skipped");
    wr_obj(5, 29'h123, 0, 1, 0);
    probe(29'h123, 0, "R7 invalid object skipped");

    wr_mask(2'd1, 29'h7FF);
    wr_obj(15, 29'h200, 1, 0, 0);
    wr_mask(2'd3, 29'h700);
    probe(29'h2FF, 0, "R5 group mask and forced receive");
    probe(29'h300, 0, "R5 group mask mismatch");
    wr_obj(2, 29'h2FF, 1, 1, 0);
    probe(29'h2FF, 0, "R6 object 15 only as fallback");
    probe(29'h2A0, 0, "R5 fallback when others miss");

    wr_obj(0, 29'h055, 1, 1, 0);
    probe(29'h055, 0, "R8 object index 0 ignored");

    step(1, 2'd0, 4'd4, 29'h3C3, 1, 1, 0, 1, 29'h3C3, 0, "R3 same cycle write not seen");
    probe(29'h3C3, 0, "R3 write seen next cycle");

    for (int n = 0; n < 400; n++) begin
      logic [28:0] pool [4];
      pool[0] = 29'h123; pool[1] = 29'h2FF; pool[2] = 29'h1ABC_DE12; pool[3] = 29'h3C3;
      if ($urandom_range(0, 3) == 0)
        step(1, 2'($urandom_range(0, 3)), 4'($urandom_range(0, 15)),
             pool[$urandom_range(0, 3)] ^ 29'($urandom_range(0, 3)),
             1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
             1'($urandom_range(0, 1)), pool[$urandom_range(0, 3)], 1'($urandom_range(0, 1)), "R3 random mix");
      else
        step(0, 2'd0, 4'd0, '0, 0, 0, 0, 1'($urandom_range(0, 1)),
             pool[$urandom_range(0, 3)] ^ 29'($urandom_range(0, 3)), 1'($urandom_range(0, 1)),
             "R6 random probe");
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule